// File: doc/BRIEF.md
# Free-Running Sync Counter Peripheral

This peripheral keeps a free-running up-counter that advances once for every system-clock cycle in which a 32,768 Hz tick-enable input is high. Software reads it over a small register bus. The bus carries an address, separate read and write strobes, a two-bit access-size code, registered read data and an error flag. The block is read-only. It holds a fixed revision word and the counter.

A processor with a 16-bit data path reads the counter in two half-word accesses. The low-half access returns bits 15:0. In the same cycle it captures bits 31:16 in a holding register. The high-half access then returns that captured value and does not sample the live counter. The two halves therefore always come from one instant, even when a carry out of bit 15 happens between the two accesses.

The counter width is a parameter. Its default is 32, and narrower counters read zero-extended. Every response appears one cycle after the strobe.

Top module: `sync_counter_top`

## Requirements
- R1: After reset the counter is zero, the holding register is zero, and the outputs `rdata_o` and `err_o` are both zero.
- R2: The counter increases by one at each clock edge where `tick_i` is high, and keeps its value at every other edge.
- R3: The counter wraps from its all-ones value to zero with no other effect.
- R4: A 32-bit read (size code 2) at address 0x00 returns 0x00000021 without error.
- R5: A 32-bit read at address 0x10 returns the counter value present in the cycle of the strobe, zero-extended to 32 bits.
- R6: A 16-bit read (size code 1) at 0x00 or 0x10 returns bits 15:0 of the addressed word in `rdata_o[15:0]` with the upper bits zero. It also loads bits 31:16 of that word into the holding register, so a low-half read of 0x00 loads zero.
- R7: A 16-bit read at 0x02 or 0x12 returns the holding register in `rdata_o[15:0]` with the upper bits zero. The holding register is left unchanged.
- R8: A write of any size to any address raises `err_o` with `rdata_o` zero, and changes neither the counter nor the holding register.
- R9: Size code 0 (8-bit) and size code 3 (reserved) raise `err_o` with zero data for both reads and writes.
- R10: A read of any other address raises `err_o`, returns zero and leaves the holding register unchanged. This includes misaligned 32-bit addresses and odd 16-bit addresses.
- R11: `rdata_o` and `err_o` are registered and valid in the cycle after the strobe. In a cycle after one with no strobe, both are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 32,768 Hz count enable, already in the clock domain |
| addr_i | input | ADDR_W (8) | Byte address of the access |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| size_i | input | 2 | Access size: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = reserved |
| rdata_o | output | 32 | Read data, one cycle after the strobe |
| err_o | output | 1 | Invalid-access flag, one cycle after the strobe |

## Verification
The counter runs under three tick patterns: a continuous tick, a sparse tick on one cycle in three, and no tick at all. These separate a counter that advances per tick from one that advances per clock, or one that stalls. Half-word pairs are read with a tick between the two halves, and one pair straddles the carry out of bit 15. A live-sampling upper half reads a different value from the captured one. A long run takes a narrowed counter across its wrap point. Writes, bad widths and bad offsets are mixed in between valid reads, so any state they disturb shows up on the next valid read.

// File: rtl/sync_cnt_pkg.sv
package sync_cnt_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    K_IDLE,
    K_WORD,
    K_LO,
    K_HI,
    K_ERR
  } resp_kind_e;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned HALF_W = DATA_W / 2;
endpackage

// File: rtl/sc_counter.sv
module sc_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + ONE; // silent wrap
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sc_decode.sv
module sc_decode
  import sync_cnt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned REV_OFF = 'h00,
  parameter int unsigned CNT_OFF = 'h10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [1:0]        size_i,
  output resp_kind_e        kind_o,
  output logic              sel_cnt_o
);
  localparam logic [ADDR_W-3:0] REV_WORD = REV_OFF[ADDR_W-1:2];
  localparam logic [ADDR_W-3:0] CNT_WORD = CNT_OFF[ADDR_W-1:2];

  logic hit_rev, hit_cnt, hit_any;

  assign hit_rev   = addr_i[ADDR_W-1:2] == REV_WORD;
  assign hit_cnt   = addr_i[ADDR_W-1:2] == CNT_WORD;
  assign hit_any   = hit_rev | hit_cnt;
  assign sel_cnt_o = hit_cnt;

  always_comb begin
    kind_o = K_ERR;
    if (wr_i) begin
      kind_o = K_ERR;
    end else if (!rd_i) begin
      kind_o = K_IDLE;
    end else begin
      unique case (acc_size_e'(size_i))
        SZ_WORD: kind_o = (hit_any && addr_i[1:0] == 2'b00) ? K_WORD : K_ERR;
        SZ_HALF: begin
          if (!hit_any || addr_i[0]) kind_o = K_ERR;
          else if (addr_i[1])        kind_o = K_HI;
          else                       kind_o = K_LO;
        end
        default: kind_o = K_ERR;
      endcase
    end
  end
endmodule

// File: rtl/sc_hold.sv
module sc_hold #(
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [HALF_W-1:0] din_i,
  output logic [HALF_W-1:0] hold_o
);
  logic [HALF_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= '0;
    else if (load_i) hold_q <= din_i;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/sync_counter_top.sv
module sync_counter_top
  import sync_cnt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned REV_OFF = 'h00,
  parameter int unsigned CNT_OFF = 'h10,
  parameter logic [31:0] REV_VAL = 32'h0000_0021
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [1:0]        size_i,
  output logic [31:0]       rdata_o,
  output logic              err_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [HALF_W-1:0] hold_q;
  logic [DATA_W-1:0] word_val, rdata_d, rdata_q;
  logic              err_d, err_q, sel_cnt, hold_ld;
  resp_kind_e        kind;

  sc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .cnt_o (cnt_q)
  );

  sc_decode #(
    .ADDR_W (ADDR_W),
    .REV_OFF(REV_OFF),
    .CNT_OFF(CNT_OFF)
  ) u_dec (
    .addr_i   (addr_i),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .size_i   (size_i),
    .kind_o   (kind),
    .sel_cnt_o(sel_cnt)
  );

  assign word_val = sel_cnt ? DATA_W'(cnt_q) : REV_VAL;
  assign hold_ld  = (kind == K_LO);

  sc_hold #(.HALF_W(HALF_W)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(hold_ld),
    .din_i (word_val[DATA_W-1:HALF_W]),
    .hold_o(hold_q)
  );

  always_comb begin
    rdata_d = '0;
    err_d   = 1'b0;
    unique case (kind)
      K_WORD:  rdata_d = word_val;
      K_LO:    rdata_d = {{HALF_W{1'b0}}, word_val[HALF_W-1:0]};
      K_HI:    rdata_d = {{HALF_W{1'b0}}, hold_q};
      K_ERR:   err_d   = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/sync_counter_chk.sv
module sync_counter_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [1:0]        size_i,
  input logic [31:0]       rdata_o,
  input logic              err_o,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [15:0]       hold_i
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_i == $past(cnt_i) + ONE);

  assert_count_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_i));

  assert_write_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> err_o && rdata_o == 32'h0);

  assert_write_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> $stable(hold_i));

  assert_rev_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && size_i == 2'd2 && addr_i == '0) |=> (rdata_o == 32'h21 && !err_o));

  assert_hi_keeps_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && size_i == 2'd1 && addr_i[1]) |=> $stable(hold_i));

  assert_bad_width_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i) && (size_i == 2'd0 || size_i == 2'd3)) |=> err_o);

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !wr_i) |=> (!err_o && rdata_o == 32'h0));

  assert_err_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rdata_o == 32'h0);
endmodule

bind sync_counter_top sync_counter_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .addr_i (addr_i),
  .rd_i   (rd_i),
  .wr_i   (wr_i),
  .size_i (size_i),
  .rdata_o(rdata_o),
  .err_o  (err_o),
  .cnt_i  (cnt_q),
  .hold_i (hold_q)
);

// File: tb/tb_sync_counter_top.sv
`timescale 1ns/1ps
module tb_sync_counter_top;
  localparam int unsigned CW   = 17;
  localparam logic [31:0] MASK = (32'h1 << CW) - 32'h1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] size = 2'd0;
  logic [7:0] addr = 8'h0;
  logic [31:0] rdata;
  logic        err;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_cnt = 0, e_data = 0;
  logic [15:0] m_hold = 0;
  logic        e_err = 0;
  string       e_tag = "R1";

  always #5 clk = ~clk;

  sync_counter_top #(.CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr),
    .rd_i(rd), .wr_i(wr), .size_i(size), .rdata_o(rdata), .err_o(err)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference, sampled at the clock edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_hold = 0; e_data = 0; e_err = 0; e_tag = "R1";
    end else begin
      logic [31:0] w;
      bit ok_word;
      ok_word = (addr[7:2] == 6'h0) || (addr[7:2] == 6'h4);
      w = (addr[7:2] == 6'h4) ? m_cnt : 32'h21;
      e_data = 0; e_err = 0;
      if (wr) begin
        e_err = 1; e_tag = (size == 2'd0 || size == 2'd3) ? "R9" : "R8";
      end else if (!rd) begin
        e_tag = "R11";
      end else if (size == 2'd2) begin
        if (ok_word && addr[1:0] == 0) begin
          e_data = w; e_tag = (addr == 0) ? "R4" : "R5";
        end else begin
          e_err = 1; e_tag = "R10";
        end
      end else if (size == 2'd1) begin
        if (!ok_word || addr[0]) begin
          e_err = 1; e_tag = "R10";
        end else if (addr[1]) begin
          e_data = {16'h0, m_hold}; e_tag = "R7";
        end else begin
          e_data = {16'h0, w[15:0]}; m_hold = w[31:16]; e_tag = "R6";
        end
      end else begin
        e_err = 1; e_tag = "R9";
      end
      if (tick) m_cnt = (m_cnt + 1) & MASK;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(rdata === e_data, e_tag, rdata, e_data);
      check(err === e_err, e_tag, {31'h0, err}, {31'h0, e_err});
    end
  end

  task automatic acc(input bit r, input bit w, input logic [1:0] s,
                     input logic [7:0] a, input bit t);
    @(negedge clk);
    rd = r; wr = w; size = s; addr = a; tick = t;
  endtask

  task automatic idle(input int n, input int every);
    for (int i = 0; i < n; i++)
      acc(0, 0, 2'd0, 8'h0, (every > 0) && (i % every == 0));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rdata === 0 && err === 0, "R1", rdata, 0);
    rst_n = 1;
    idle(2, 0);
    check(rdata === 0 && err === 0, "R1", rdata, 0);
    // revision and counter, continuous tick
    acc(1, 0, 2'd2, 8'h00, 1);
    for (int i = 0; i < 10; i++) acc(1, 0, 2'd2, 8'h10, 1);
    // sparse tick
    for (int i = 0; i < 12; i++) acc(i % 2 == 0, 0, 2'd2, 8'h10, i % 3 == 0);
    // no tick
    for (int i = 0; i < 4; i++) acc(1, 0, 2'd2, 8'h10, 0);
    // half-word pairs with tick in between
    acc(1, 0, 2'd1, 8'h10, 1); acc(0, 0, 2'd0, 8'h0, 1); acc(1, 0, 2'd1, 8'h12, 1);
    acc(1, 0, 2'd1, 8'h00, 0); acc(1, 0, 2'd1, 8'h02, 0);
    acc(1, 0, 2'd1, 8'h12, 1); acc(1, 0, 2'd1, 8'h02, 0);
    // writes of every size, then confirm state via reads
    acc(1, 0, 2'd1, 8'h10, 0);
    for (int s = 0; s < 4; s++) begin
      acc(0, 1, 2'(s), 8'h10, 1);
      acc(1, 1, 2'(s), 8'h12, 0);
      acc(0, 1, 2'(s), 8'h00, 0);
    end
    acc(1, 0, 2'd1, 8'h12, 0); acc(1, 0, 2'd2, 8'h10, 0);
    // bad widths
    acc(1, 0, 2'd0, 8'h10, 1); acc(1, 0, 2'd3, 8'h00, 0); acc(1, 0, 2'd0, 8'h00, 0);
    // bad offsets
    acc(1, 0, 2'd1, 8'h10, 0);
    acc(1, 0, 2'd2, 8'h04, 0); acc(1, 0, 2'd2, 8'h14, 1); acc(1, 0, 2'd2, 8'h12, 0);
    acc(1, 0, 2'd1, 8'h11, 0); acc(1, 0, 2'd1, 8'h06, 0); acc(1, 0, 2'd1, 8'h04, 0);
    acc(1, 0, 2'd2, 8'hFC, 0);
    acc(1, 0, 2'd1, 8'h12, 0);
    idle(3, 0);
    // approach carry out of bit 15
    while (m_cnt < 32'hFFFC) acc(0, 0, 2'd0, 8'h0, 1);
    for (int i = 0; i < 6; i++) begin
      acc(1, 0, 2'd1, 8'h10, 1);
      acc(1, 0, 2'd1, 8'h12, 1);
      acc(1, 0, 2'd2, 8'h10, 0);
    end
    // approach wrap
    while (m_cnt < (MASK - 32'h4)) acc(0, 0, 2'd0, 8'h0, 1);
    for (int i = 0; i < 8; i++) acc(1, 0, 2'd2, 8'h10, 1);
    acc(1, 0, 2'd2, 8'h10, 0);
    @(negedge clk);
    check(e_data < 32'h10 && rdata === e_data, "R3", rdata, e_data);
    acc(0, 0, 2'd0, 8'h0, 0);
    idle(2, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule